// File: doc/BRIEF.md
# Sparse Token-Passing Channel Readout

This block decides which of a chip's 64 front-end channels are read out and in what order. Each channel reports a threshold crossing and a peak-found flag. A channel whose peak was found is flagged as holding data. With neighbour mode on, a triggering channel also flags the channels on either side of it, even if those channels did not fire. The neighbour relation runs across the chip edge, so the top channel of one chip and the bottom channel of the next chip count as neighbours. A per-channel mask removes a channel from both triggering and readout.

Readout is driven by a token that runs through a daisy chain of chips. When this chip receives the token, it takes a snapshot of its flags. It then visits the flagged channels in ascending address order, one channel per clock, and spends no cycles on unflagged channels. For each visited channel it drives a one-hot select for the analog multiplexer and the 6-bit channel address. After the last visited channel it passes the token to the next chip with a one-cycle pulse and returns to idle. Flags raised while a pass is running are kept for the following pass.

Top module: `sparse_token_readout`

## Requirements
- R1: While reset is high, and in the first cycle after it, `addr_valid_o`, `token_out_o` and `mux_sel_o` are all zero.
- R2: A channel is read only if it was flagged, and a channel is flagged only if it is unmasked and either its own peak-found input was high or a neighbour rule (R6, R7) applies. The reads of one pass take consecutive cycles, with no idle cycle for skipped channels.
- R3: A pass starts when `token_in` is sampled high in idle. The first address appears at the second rising edge after that sample, and the addresses of one pass rise strictly from channel 0 toward channel 63.
- R4: While `addr_valid_o` is high, `mux_sel_o` has exactly one bit set, at the position given by `addr_o`. Otherwise `mux_sel_o` is zero.
- R5: `token_out_o` is high for exactly one cycle. That cycle follows the last address of the pass, or comes one cycle after acceptance if no channel was flagged. After it the block is idle.
- R6: With `nbr_en` high, an unmasked channel whose threshold input is high flags channels i-1 and i+1. With `nbr_en` low, a threshold crossing alone flags nothing.
- R7: With `nbr_en` high, `nbr_lo_i` flags channel 0 and `nbr_hi_i` flags channel 63. `nbr_lo_o` equals the unmasked threshold of channel 0, and `nbr_hi_o` equals the unmasked threshold of channel 63.
- R8: A masked channel is never flagged, never read and does not trigger its neighbours.
- R9: Reading a channel clears its flag, so a second pass without new hits reads nothing. A flag raised during a pass is read in the next pass, not the current one. A `token_in` that arrives during a pass is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 64 | Per-channel threshold crossing |
| peak_i | input | 64 | Per-channel peak-found flag |
| mask_i | input | 64 | Per-channel disable |
| nbr_en | input | 1 | Neighbour flagging enable |
| nbr_lo_i | input | 1 | Top channel of the lower chip triggered |
| nbr_hi_i | input | 1 | Bottom channel of the upper chip triggered |
| token_in | input | 1 | Read token from the previous chip |
| nbr_lo_o | output | 1 | Channel 0 triggered, to the lower chip |
| nbr_hi_o | output | 1 | Channel 63 triggered, to the upper chip |
| addr_o | output | 6 | Address of the channel being read |
| addr_valid_o | output | 1 | `addr_o` and `mux_sel_o` are valid |
| mux_sel_o | output | 64 | One-hot analog multiplexer select |
| token_out_o | output | 1 | Read token to the next chip, one-cycle pulse |

## Verification
The table-driven part tries these flag patterns: sparse peaks, a threshold crossing with and without neighbour mode, hits at channels 0 and 63, external neighbour inputs, masks on the hit channel and on its neighbour, and every channel flagged. Together they separate the own-peak rule, the neighbour rule, the edge cases at both ends and the mask. Each pass compares the full address sequence and the placement of the token pulse against a list worked out from the requirements. This catches skipped or repeated channels, wrong order and off-by-one token timing. Directed tests cover reset, a hit and a token that arrive during a pass, and an empty pass.

// File: rtl/srd_pkg.sv
package srd_pkg;

    localparam int unsigned CH_COUNT = 64;
    localparam int unsigned CH_ADDR_W = $clog2(CH_COUNT);

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_SCAN = 1'b1
    } rd_state_t;

    // one channel's contribution to the flag set
    typedef struct packed {
        logic own;    // peak found on this channel
        logic left;   // lower neighbour triggered
        logic right;  // upper neighbour triggered
        logic off;    // channel masked
    } ch_cause_t;

    function automatic logic cause_flags(input ch_cause_t c, input logic nen);
        return !c.off && (c.own || (nen && (c.left || c.right)));
    endfunction

endpackage

// File: rtl/srd_flag_gen.sv
module srd_flag_gen
    import srd_pkg::*;
#(
    parameter int unsigned NCH = CH_COUNT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] hit_i,
    input  logic [NCH-1:0] peak_i,
    input  logic [NCH-1:0] mask_i,
    input  logic           nbr_en,
    input  logic           nbr_lo_i,
    input  logic           nbr_hi_i,
    input  logic           capture,
    output logic           nbr_lo_o,
    output logic           nbr_hi_o,
    output logic [NCH-1:0] pend_o
);

    logic [NCH-1:0] trig;
    logic [NCH-1:0] set_vec;
    logic [NCH-1:0] pend_q;

    assign trig     = hit_i & ~mask_i;
    assign nbr_lo_o = trig[0];
    assign nbr_hi_o = trig[NCH-1];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ch_cause_t cause;
        logic      lo_nb;
        logic      hi_nb;
        if (g == 0) begin : g_bot
            assign lo_nb = nbr_lo_i;
        end else begin : g_lo
            assign lo_nb = trig[g-1];
        end
        if (g == NCH - 1) begin : g_top
            assign hi_nb = nbr_hi_i;
        end else begin : g_hi
            assign hi_nb = trig[g+1];
        end
        assign cause.own   = peak_i[g];
        assign cause.left  = lo_nb;
        assign cause.right = hi_nb;
        assign cause.off   = mask_i[g];
        assign set_vec[g]  = cause_flags(cause, nbr_en);
    end

    // capture hands the pending set to the scanner and restarts collection
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (capture) begin
            pend_q <= set_vec;
        end else begin
            pend_q <= pend_q | set_vec;
        end
    end

    assign pend_o = pend_q;

    // a flag seen at one edge survives unless a capture took it
    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ((pend_q & $past(pend_q)) == $past(pend_q))) else $error("flag lost"); // R9

endmodule

// File: rtl/srd_lowest.sv
module srd_lowest #(
    parameter int unsigned N  = 64,
    parameter int unsigned AW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [AW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = AW'(i);
        end
    end

    assign found = |vec;

endmodule

// File: rtl/srd_token_ctl.sv
module srd_token_ctl
    import srd_pkg::*;
#(
    parameter int unsigned NCH = CH_COUNT,
    parameter int unsigned AW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           token_in,
    input  logic [NCH-1:0] pend_i,
    output logic           capture,
    output logic [AW-1:0]  addr_o,
    output logic           addr_valid_o,
    output logic [NCH-1:0] mux_sel_o,
    output logic           token_out_o
);

    rd_state_t      state_q;
    logic [NCH-1:0] active_q;
    logic           found;
    logic [AW-1:0]  pick;
    logic [AW-1:0]  addr_q;
    logic           valid_q;
    logic [NCH-1:0] sel_q;
    logic           tok_q;

    srd_lowest #(.N(NCH), .AW(AW)) u_pick (
        .vec   (active_q),
        .found (found),
        .idx   (pick)
    );

    assign capture = (state_q == RD_IDLE) && token_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RD_IDLE;
            active_q <= '0;
            addr_q   <= '0;
            valid_q  <= 1'b0;
            sel_q    <= '0;
            tok_q    <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            sel_q   <= '0;
            tok_q   <= 1'b0;
            case (state_q)
                RD_IDLE: begin
                    if (token_in) begin
                        active_q <= pend_i;
                        state_q  <= RD_SCAN;
                    end
                end
                RD_SCAN: begin
                    if (found) begin
                        addr_q         <= pick;
                        valid_q        <= 1'b1;
                        sel_q[pick]    <= 1'b1;
                        active_q[pick] <= 1'b0;
                    end else begin
                        tok_q   <= 1'b1;
                        state_q <= RD_IDLE;
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    assign addr_o       = addr_q;
    assign addr_valid_o = valid_q;
    assign mux_sel_o    = sel_q;
    assign token_out_o  = tok_q;

    AST_TOKEN_PULSE: assert property (@(posedge clk) disable iff (rst)
        tok_q |=> !tok_q) else $error("token held"); // R5
    AST_TOKEN_NO_READ: assert property (@(posedge clk) disable iff (rst)
        tok_q |-> !valid_q) else $error("token with read"); // R5
    AST_SEL_MATCH: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> ($countones(sel_q) == 1 && sel_q[addr_q])) else $error("select"); // R4
    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> (sel_q == '0)) else $error("select idle"); // R4
    AST_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (valid_q && $past(valid_q)) |-> (addr_q > $past(addr_q))) else $error("order"); // R3

endmodule

// File: rtl/sparse_token_readout.sv
module sparse_token_readout
    import srd_pkg::*;
#(
    parameter int unsigned NCH = CH_COUNT,
    localparam int unsigned AW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] hit_i,
    input  logic [NCH-1:0] peak_i,
    input  logic [NCH-1:0] mask_i,
    input  logic           nbr_en,
    input  logic           nbr_lo_i,
    input  logic           nbr_hi_i,
    input  logic           token_in,
    output logic           nbr_lo_o,
    output logic           nbr_hi_o,
    output logic [AW-1:0]  addr_o,
    output logic           addr_valid_o,
    output logic [NCH-1:0] mux_sel_o,
    output logic           token_out_o
);

    logic           capture;
    logic [NCH-1:0] pend;

    srd_flag_gen #(.NCH(NCH)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .hit_i    (hit_i),
        .peak_i   (peak_i),
        .mask_i   (mask_i),
        .nbr_en   (nbr_en),
        .nbr_lo_i (nbr_lo_i),
        .nbr_hi_i (nbr_hi_i),
        .capture  (capture),
        .nbr_lo_o (nbr_lo_o),
        .nbr_hi_o (nbr_hi_o),
        .pend_o   (pend)
    );

    srd_token_ctl #(.NCH(NCH), .AW(AW)) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .token_in     (token_in),
        .pend_i       (pend),
        .capture      (capture),
        .addr_o       (addr_o),
        .addr_valid_o (addr_valid_o),
        .mux_sel_o    (mux_sel_o),
        .token_out_o  (token_out_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!addr_valid_o && !token_out_o)) else $error("reset state"); // R1

endmodule

// File: tb/tb_sparse_token_readout.sv
module tb_sparse_token_readout;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [63:0] peak;
        logic [63:0] hit;
        logic [63:0] mask;
        logic        nen;
        logic        nlo;
        logic        nhi;
        logic [63:0] exp;
        logic        exp_lo;
        logic        exp_hi;
    } vec_t;

    localparam int NV = 12;
    // peak, hit, mask, nen, nlo, nhi, expected flags, expected nbr_lo_o, nbr_hi_o
    localparam vec_t VECS [NV] = '{
        '{64'h408, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, 64'h408, 1'b0, 1'b0},            // R2 sparse
        '{64'h0, 64'h20, 64'h0, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0},               // R6 no nbr
        '{64'h20, 64'h20, 64'h0, 1'b1, 1'b0, 1'b0, 64'h70, 1'b0, 1'b0},             // R6
        '{64'h1, 64'h1, 64'h0, 1'b1, 1'b0, 1'b0, 64'h3, 1'b1, 1'b0},                // R7 low edge
        '{64'h0, 64'h0, 64'h0, 1'b1, 1'b1, 1'b0, 64'h1, 1'b0, 1'b0},                // R7 from lower chip
        '{64'h0, 64'h0, 64'h0, 1'b1, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b0}, // R7 upper chip
        '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 1'b1, 1'b0, 1'b0,
          64'hC000_0000_0000_0000, 1'b0, 1'b1},                                      // R7 top edge
        '{64'h20, 64'h20, 64'h20, 1'b1, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0},             // R8 masked hit
        '{64'h20, 64'h20, 64'h40, 1'b1, 1'b0, 1'b0, 64'h30, 1'b0, 1'b0},            // R8 masked nbr
        '{64'h1, 64'h1, 64'h1, 1'b1, 1'b1, 1'b0, 64'h0, 1'b0, 1'b0},                // R8 mask ch0
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0,
          64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},                                      // R2 all
        '{64'h0, 64'h0, 64'h0, 1'b0, 1'b1, 1'b1, 64'h0, 1'b0, 1'b0}                 // R6 ext off
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] hit_i, peak_i, mask_i;
    logic        nbr_en, nbr_lo_i, nbr_hi_i, token_in;
    logic        nbr_lo_o, nbr_hi_o;
    logic [5:0]  addr_o;
    logic        addr_valid_o;
    logic [63:0] mux_sel_o;
    logic        token_out_o;

    int checks = 0;
    int errors = 0;

    sparse_token_readout dut (
        .clk(clk), .rst(rst), .hit_i(hit_i), .peak_i(peak_i), .mask_i(mask_i),
        .nbr_en(nbr_en), .nbr_lo_i(nbr_lo_i), .nbr_hi_i(nbr_hi_i), .token_in(token_in),
        .nbr_lo_o(nbr_lo_o), .nbr_hi_o(nbr_hi_o), .addr_o(addr_o),
        .addr_valid_o(addr_valid_o), .mux_sel_o(mux_sel_o), .token_out_o(token_out_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic clear_inputs();
        hit_i = '0; peak_i = '0; mask_i = '0;
        nbr_en = 1'b0; nbr_lo_i = 1'b0; nbr_hi_i = 1'b0;
    endtask

    // one readout pass; inject is a peak set applied while the pass runs
    task automatic run_pass(input logic [63:0] exp, input logic [63:0] inject,
                            input logic tok_again, input string rq);
        logic first;
        first = 1'b1;
        @(negedge clk); token_in = 1'b1;
        @(negedge clk); token_in = tok_again; peak_i = inject;
        for (int i = 0; i < 64; i++) begin
            if (exp[i]) begin
                @(negedge clk);
                if (first) begin token_in = 1'b0; peak_i = '0; first = 1'b0; end
                check(addr_valid_o === 1'b1 && addr_o === 6'(i) && !token_out_o,
                      {rq, " read addr"}, {57'd0, addr_valid_o, addr_o}, {57'd1, 7'(i)});
                check(mux_sel_o === (64'd1 << i), "R4 select", mux_sel_o, 64'd1 << i);
            end
        end
        @(negedge clk);
        if (first) begin token_in = 1'b0; peak_i = '0; end
        check(token_out_o === 1'b1 && addr_valid_o === 1'b0, "R5 token out",
              {62'd0, token_out_o, addr_valid_o}, 64'd2);
        check(mux_sel_o === '0, "R4 select idle", mux_sel_o, 64'd0);
        @(negedge clk);
        check(token_out_o === 1'b0 && addr_valid_o === 1'b0, "R5 single pulse",
              {62'd0, token_out_o, addr_valid_o}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; token_in = 1'b0;
        clear_inputs();
        repeat (3) @(negedge clk);
        check(addr_valid_o === 1'b0 && token_out_o === 1'b0 && mux_sel_o === '0,
              "R1 in reset", {62'd0, addr_valid_o, token_out_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(addr_valid_o === 1'b0 && token_out_o === 1'b0 && mux_sel_o === '0,
              "R1 after reset", {62'd0, addr_valid_o, token_out_o}, 64'd0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            peak_i = VECS[v].peak; hit_i = VECS[v].hit; mask_i = VECS[v].mask;
            nbr_en = VECS[v].nen; nbr_lo_i = VECS[v].nlo; nbr_hi_i = VECS[v].nhi;
            #1;
            check(nbr_lo_o === VECS[v].exp_lo && nbr_hi_o === VECS[v].exp_hi, "R7 nbr outputs",
                  {62'd0, nbr_lo_o, nbr_hi_o}, {62'd0, VECS[v].exp_lo, VECS[v].exp_hi});
            @(negedge clk);
            clear_inputs();
            run_pass(VECS[v].exp, 64'h0, 1'b0, $sformatf("R2 R3 R6 R8 vec%0d", v));
        end

        // R9: flags cleared after reading, next pass is empty
        @(negedge clk); peak_i = 64'h84;
        @(negedge clk); clear_inputs();
        run_pass(64'h84, 64'h2, 1'b1, "R9 first pass");
        run_pass(64'h2, 64'h0, 1'b0, "R9 held hit");
        run_pass(64'h0, 64'h0, 1'b0, "R9 empty pass");

        // R3: first address exactly two edges after the token sample
        @(negedge clk); peak_i = 64'h10;
        @(negedge clk); clear_inputs(); token_in = 1'b1;
        @(negedge clk); token_in = 1'b0;
        check(addr_valid_o === 1'b0, "R3 not yet valid", {63'd0, addr_valid_o}, 64'd0);
        @(negedge clk);
        check(addr_valid_o === 1'b1 && addr_o === 6'd4, "R3 first read",
              {57'd0, addr_valid_o, addr_o}, {57'd1, 7'd4});
        @(negedge clk);
        check(token_out_o === 1'b1, "R5 token after read", {63'd0, token_out_o}, 64'd1);
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule